// File: doc/BRIEF.md
# DS1 Robbed-Bit Signaling Extractor

This block sits behind a DS1 framer that has already found frame and superframe alignment. Each clock carries one received PCM bit together with its timeslot number (0 to 23), its bit weight inside the octet (7 is the most significant bit, 0 the least), and the frame number inside the 24-frame extended superframe (1 to 24). A lock input from the framer qualifies the stream. In the four signaling frames, the block takes the least significant bit of every timeslot and stores it in a per-channel table of four signaling bits. A host can read and write that table through a small synchronous port.

The block also drives an auxiliary serial pin that has two functions. In timeslot mode, the pin carries bit 0 of the current timeslot number. In signaling mode, the pin replays each channel's four stored signaling bits in the low four bit times of that channel's octet, in step with a retimed copy of the PCM stream.

Top module: `ds1_sig_extract`

## Requirements
- R1: After reset, every table entry reads 0, the pin-mode bit reads 0 (timeslot mode), and `hst_rdata`, `pcm_out` and `aux_pin` are 0.
- R2: When `rx_locked` is 1, `rx_bitpos` is 0 and `rx_frame` is 6, the value of `rx_bit` is written into bit 3 (signaling A) of the entry for `rx_ts`.
- R3: Under the same conditions, frame 12 writes bit 2 (B), frame 18 writes bit 1 (C) and frame 24 writes bit 0 (D) of the entry for `rx_ts`.
- R4: No entry changes in any other frame, at any bit weight other than 0, or while `rx_locked` is 0, unless the host writes it.
- R5: Host addresses 0 to 23 select table entries, with data in bits 3..0. Address 32 (0x20) holds the pin-mode bit in bit 0 (1 selects signaling mode). A write takes effect at the clock edge. A read pulse loads `hst_rdata` at the edge, and `hst_rdata` holds that value until the next read. Every other address reads 0 and ignores writes.
- R6: When a host write targets the same entry that a capture writes in the same cycle, the capture takes effect and the host write is dropped. A host write to a different entry in that cycle still takes effect.
- R7: In timeslot mode, `aux_pin` equals bit 0 of the `rx_ts` value presented one clock earlier.
- R8: In signaling mode, when the previous cycle had bit weight 3, 2, 1 or 0, `aux_pin` carries entry bit 3, 2, 1 or 0 (A, B, C or D) of the previous cycle's timeslot. The entry is read as it stood before that cycle's capture.
- R9: In signaling mode, when the previous cycle had bit weight 7 to 4, `aux_pin` is 0.
- R10: `pcm_out` is `rx_bit` delayed by one clock, so `aux_pin` lines up bit for bit with the octet that `pcm_out` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received PCM bit |
| rx_ts | input | 5 | Timeslot number of the current bit, 0 to 23 |
| rx_bitpos | input | 3 | Bit weight inside the octet, 7 down to 0 |
| rx_frame | input | 5 | Frame number in the superframe, 1 to 24 |
| rx_locked | input | 1 | Framer lock; qualifies capture |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | 6 | Host address |
| hst_wdata | input | 4 | Host write data |
| hst_rdata | output | 4 | Host read data, valid one clock after the read strobe |
| pcm_out | output | 1 | Retimed PCM bit |
| aux_pin | output | 1 | Timeslot bit 0 or replayed signaling bit |

## Verification
Whole superframes are streamed with data patterns that change with frame, timeslot and bit weight. With this variation, a capture into the wrong frame, wrong bit slot or wrong channel leaves a table entry that differs from the expected one. The first pass runs in timeslot mode. The second pass runs in signaling mode, so that the pin replays values captured earlier while new captures happen in the same pass; this separates the mapping of bit weight to signaling bit and the blanking of the upper nibble from any off-by-one error in the replay. A third pass is streamed with lock removed; its data differs from the earlier passes, so any capture made without lock shows up in the readback. Single-cycle host-versus-capture collisions, to the same entry and to a different entry, show which source wins and that the other entry is unaffected.

// File: rtl/ds1_sig_pkg.sv
package ds1_sig_pkg;
  typedef enum logic {
    PIN_TSNUM  = 1'b0,
    PIN_SIGNAL = 1'b1
  } pin_mode_e;

  localparam int unsigned DEF_NUM_CH    = 24;
  localparam int unsigned DEF_SIG_W     = 4;
  localparam int unsigned DEF_FRAMES    = 24;
  localparam int unsigned DEF_OCT_W     = 8;
  localparam int unsigned DEF_CTRL_ADDR = 32;
endpackage

// File: rtl/ds1_sig_rst_sync.sv
module ds1_sig_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ds1_sig_capture.sv
// Decodes the signaling frames and picks the table bit to be written.
module ds1_sig_capture #(
  parameter int unsigned NUM_CH = 24,
  parameter int unsigned SIG_W  = 4,
  parameter int unsigned FRAMES = 24,
  parameter int unsigned TS_W   = 5,
  parameter int unsigned FR_W   = 5,
  parameter int unsigned BP_W   = 3,
  parameter int unsigned SB_W   = 2
) (
  input  logic [TS_W-1:0] ts,
  input  logic [BP_W-1:0] bitpos,
  input  logic [FR_W-1:0] frame,
  input  logic            locked,
  output logic            cap_en,
  output logic [SB_W-1:0] cap_bit
);
  localparam int unsigned SPAN = FRAMES / SIG_W;

  logic [SIG_W-1:0] frame_hit;

  genvar k;
  generate
    for (k = 0; k < SIG_W; k++) begin : g_hit
      assign frame_hit[k] = (frame == FR_W'((k + 1) * SPAN));
    end
  endgenerate

  always_comb begin
    cap_bit = '0;
    for (int j = 0; j < SIG_W; j++) begin
      if (frame_hit[j]) cap_bit = SB_W'(SIG_W - 1 - j);
    end
  end

  assign cap_en = locked && (bitpos == '0) && (|frame_hit) && (ts < TS_W'(NUM_CH));
endmodule

// File: rtl/ds1_sig_regfile.sv
// Per-channel signaling table plus pin-mode bit, host port with registered read.
module ds1_sig_regfile
  import ds1_sig_pkg::*;
#(
  parameter int unsigned NUM_CH    = 24,
  parameter int unsigned SIG_W     = 4,
  parameter int unsigned CTRL_ADDR = 32,
  parameter int unsigned TS_W      = 5,
  parameter int unsigned SB_W      = 2,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [TS_W-1:0]   cap_ts,
  input  logic [SB_W-1:0]   cap_bit,
  input  logic              cap_val,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [SIG_W-1:0]  hst_wdata,
  output logic [SIG_W-1:0]  hst_rdata,
  output logic [SIG_W-1:0]  tab [NUM_CH],
  output pin_mode_e         mode
);
  logic              addr_is_ent;
  logic              addr_is_ctrl;
  logic [TS_W-1:0]   wr_idx;
  logic [SIG_W-1:0]  rd_nxt;
  pin_mode_e         mode_nxt;
  logic              mode_ce;

  assign addr_is_ent  = (hst_addr < ADDR_W'(NUM_CH));
  assign addr_is_ctrl = (hst_addr == ADDR_W'(CTRL_ADDR));
  assign wr_idx       = hst_addr[TS_W-1:0];

  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : g_ent
      logic [SIG_W-1:0] ent_nxt;
      logic             ent_ce;

      always_comb begin
        ent_nxt = tab[i];
        ent_ce  = 1'b0;
        if (cap_en && (cap_ts == TS_W'(i))) begin
          ent_nxt[cap_bit] = cap_val;
          ent_ce           = 1'b1;
        end else if (hst_wr && addr_is_ent && (wr_idx == TS_W'(i))) begin
          ent_nxt = hst_wdata;
          ent_ce  = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tab[i] <= '0;
        else if (ent_ce) tab[i] <= ent_nxt;
      end
    end
  endgenerate

  always_comb begin
    mode_ce  = hst_wr && addr_is_ctrl;
    mode_nxt = pin_mode_e'(hst_wdata[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode <= PIN_TSNUM;
    else if (mode_ce) mode <= mode_nxt;
  end

  always_comb begin
    if (addr_is_ent)       rd_nxt = tab[wr_idx];
    else if (addr_is_ctrl) rd_nxt = {{(SIG_W-1){1'b0}}, mode};
    else                   rd_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hst_rdata <= '0;
    else if (hst_rd) hst_rdata <= rd_nxt;
  end
endmodule

// File: rtl/ds1_sig_serializer.sv
// Retimes PCM and drives the dual-function auxiliary pin in the same cycle.
module ds1_sig_serializer
  import ds1_sig_pkg::*;
#(
  parameter int unsigned NUM_CH = 24,
  parameter int unsigned SIG_W  = 4,
  parameter int unsigned TS_W   = 5,
  parameter int unsigned BP_W   = 3,
  parameter int unsigned SB_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic [TS_W-1:0]  ts,
  input  logic [BP_W-1:0]  bitpos,
  input  pin_mode_e        mode,
  input  logic [SIG_W-1:0] tab [NUM_CH],
  output logic             pcm_out,
  output logic             aux_pin
);
  logic aux_nxt;
  logic low_nibble;
  logic ts_ok;

  assign low_nibble = (bitpos < BP_W'(SIG_W));
  assign ts_ok      = (ts < TS_W'(NUM_CH));

  always_comb begin
    aux_nxt = 1'b0;
    if (mode == PIN_TSNUM)       aux_nxt = ts[0];
    else if (low_nibble && ts_ok) aux_nxt = tab[ts][bitpos[SB_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcm_out <= 1'b0;
      aux_pin <= 1'b0;
    end else begin
      pcm_out <= rx_bit;
      aux_pin <= aux_nxt;
    end
  end
endmodule

// File: rtl/ds1_sig_extract.sv
module ds1_sig_extract
  import ds1_sig_pkg::*;
#(
  parameter int unsigned NUM_CH    = DEF_NUM_CH,
  parameter int unsigned SIG_W     = DEF_SIG_W,
  parameter int unsigned FRAMES    = DEF_FRAMES,
  parameter int unsigned OCT_W     = DEF_OCT_W,
  parameter int unsigned CTRL_ADDR = DEF_CTRL_ADDR,
  localparam int unsigned TS_W     = $clog2(NUM_CH),
  localparam int unsigned FR_W     = $clog2(FRAMES + 1),
  localparam int unsigned BP_W     = $clog2(OCT_W),
  localparam int unsigned SB_W     = $clog2(SIG_W),
  localparam int unsigned ADDR_W   = $clog2(CTRL_ADDR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic [TS_W-1:0]   rx_ts,
  input  logic [BP_W-1:0]   rx_bitpos,
  input  logic [FR_W-1:0]   rx_frame,
  input  logic              rx_locked,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [SIG_W-1:0]  hst_wdata,
  output logic [SIG_W-1:0]  hst_rdata,
  output logic              pcm_out,
  output logic              aux_pin
);
  logic             rst_sync_n;
  logic             cap_en;
  logic [SB_W-1:0]  cap_bit;
  logic [SIG_W-1:0] sig_tab [NUM_CH];
  pin_mode_e        sig_mode;

  ds1_sig_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ds1_sig_capture #(
    .NUM_CH (NUM_CH), .SIG_W (SIG_W), .FRAMES (FRAMES),
    .TS_W (TS_W), .FR_W (FR_W), .BP_W (BP_W), .SB_W (SB_W)
  ) u_cap (
    .ts      (rx_ts),
    .bitpos  (rx_bitpos),
    .frame   (rx_frame),
    .locked  (rx_locked),
    .cap_en  (cap_en),
    .cap_bit (cap_bit)
  );

  ds1_sig_regfile #(
    .NUM_CH (NUM_CH), .SIG_W (SIG_W), .CTRL_ADDR (CTRL_ADDR),
    .TS_W (TS_W), .SB_W (SB_W), .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cap_en    (cap_en),
    .cap_ts    (rx_ts),
    .cap_bit   (cap_bit),
    .cap_val   (rx_bit),
    .hst_wr    (hst_wr),
    .hst_rd    (hst_rd),
    .hst_addr  (hst_addr),
    .hst_wdata (hst_wdata),
    .hst_rdata (hst_rdata),
    .tab       (sig_tab),
    .mode      (sig_mode)
  );

  ds1_sig_serializer #(
    .NUM_CH (NUM_CH), .SIG_W (SIG_W), .TS_W (TS_W), .BP_W (BP_W), .SB_W (SB_W)
  ) u_ser (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rx_bit  (rx_bit),
    .ts      (rx_ts),
    .bitpos  (rx_bitpos),
    .mode    (sig_mode),
    .tab     (sig_tab),
    .pcm_out (pcm_out),
    .aux_pin (aux_pin)
  );
endmodule

// File: rtl/ds1_sig_extract_chk.sv
module ds1_sig_extract_chk #(
  parameter int unsigned NUM_CH    = 24,
  parameter int unsigned SIG_W     = 4,
  parameter int unsigned FRAMES    = 24,
  parameter int unsigned CTRL_ADDR = 32,
  parameter int unsigned TS_W      = 5,
  parameter int unsigned FR_W      = 5,
  parameter int unsigned BP_W      = 3,
  parameter int unsigned SB_W      = 2,
  parameter int unsigned ADDR_W    = 6
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              rx_bit,
  input logic [TS_W-1:0]   rx_ts,
  input logic [BP_W-1:0]   rx_bitpos,
  input logic [FR_W-1:0]   rx_frame,
  input logic              rx_locked,
  input logic              hst_wr,
  input logic [ADDR_W-1:0] hst_addr,
  input logic [SIG_W-1:0]  hst_wdata,
  input logic              mode,
  input logic [SIG_W-1:0]  tab [NUM_CH],
  input logic              pcm_out,
  input logic              aux_pin
);
  logic [NUM_CH*SIG_W-1:0] tab_flat;
  logic                    ts_ok;
  logic                    cur_sig;

  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : g_flat
      assign tab_flat[i*SIG_W +: SIG_W] = tab[i];
    end
  endgenerate

  assign ts_ok   = (rx_ts < TS_W'(NUM_CH));
  assign cur_sig = ts_ok ? tab[rx_ts][rx_bitpos[SB_W-1:0]] : 1'b0;

  AST_TS_MODE: assert property (@(posedge clk) disable iff (!rst_ok)
    !mode |=> aux_pin == $past(rx_ts[0])); // R7

  AST_SIG_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode && ts_ok && rx_bitpos < BP_W'(SIG_W)) |=> aux_pin == $past(cur_sig)); // R8

  AST_SIG_HIGH_BLANK: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode && rx_bitpos >= BP_W'(SIG_W)) |=> !aux_pin); // R9

  AST_PCM_RETIME: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> pcm_out == $past(rx_bit)); // R10

  AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_ok)
    (rx_locked && rx_bitpos == '0 && ts_ok && rx_frame == FR_W'(FRAMES / SIG_W))
      |=> tab[$past(rx_ts)][SIG_W-1] == $past(rx_bit)); // R2

  AST_NO_CAPTURE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_ok)
    (!rx_locked && !hst_wr) |=> $stable(tab_flat)); // R4

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_ok)
    (hst_wr && hst_addr == ADDR_W'(CTRL_ADDR)) |=> mode == $past(hst_wdata[0])); // R5
endmodule

bind ds1_sig_extract ds1_sig_extract_chk #(
  .NUM_CH (NUM_CH), .SIG_W (SIG_W), .FRAMES (FRAMES), .CTRL_ADDR (CTRL_ADDR),
  .TS_W (TS_W), .FR_W (FR_W), .BP_W (BP_W), .SB_W (SB_W), .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .rx_bit    (rx_bit),
  .rx_ts     (rx_ts),
  .rx_bitpos (rx_bitpos),
  .rx_frame  (rx_frame),
  .rx_locked (rx_locked),
  .hst_wr    (hst_wr),
  .hst_addr  (hst_addr),
  .hst_wdata (hst_wdata),
  .mode      (sig_mode),
  .tab       (sig_tab),
  .pcm_out   (pcm_out),
  .aux_pin   (aux_pin)
);

// File: tb/ds1_sig_extract_bench.sv
module ds1_sig_extract_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       rx_bit;
  logic [4:0] rx_ts;
  logic [2:0] rx_bitpos;
  logic [4:0] rx_frame;
  logic       rx_locked;
  logic       hst_wr;
  logic       hst_rd;
  logic [5:0] hst_addr;
  logic [3:0] hst_wdata;
  logic [3:0] hst_rdata;
  logic       pcm_out;
  logic       aux_pin;

  ds1_sig_extract u_ds1_sig_extract (
    .clk (clk), .rst_n (rst_n), .rx_bit (rx_bit), .rx_ts (rx_ts),
    .rx_bitpos (rx_bitpos), .rx_frame (rx_frame), .rx_locked (rx_locked),
    .hst_wr (hst_wr), .hst_rd (hst_rd), .hst_addr (hst_addr),
    .hst_wdata (hst_wdata), .hst_rdata (hst_rdata),
    .pcm_out (pcm_out), .aux_pin (aux_pin)
  );

  typedef struct {
    logic  pin;
    logic  dat;
    string tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [3:0] m_tab [24];
  logic       m_mode;
  int         n_chk;
  int         n_fail;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Scoreboard monitor: one expected item per driven bit cycle.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " aux_pin"}, {31'd0, aux_pin}, {31'd0, e.pin});
        check("R10 pcm_out", {31'd0, pcm_out}, {31'd0, e.dat});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  function automatic logic pat(int fr, int ts, int bp, int seed);
    return ((fr * 5 + ts * 3 + bp * 7 + seed * 11) % 4) < 2;
  endfunction

  function automatic logic [3:0] mread(int a);
    if (a < 24)  return m_tab[a];
    if (a == 32) return {3'b000, m_mode};
    return 4'h0;
  endfunction

  // Drive one bit cycle, push the expected pin/data, then update the model.
  task automatic drive_bit(int ts, int bp, int fr, logic lk, logic d);
    exp_t e;
    @(negedge clk);
    rx_ts = 5'(ts); rx_bitpos = 3'(bp); rx_frame = 5'(fr);
    rx_locked = lk; rx_bit = d;
    if (!m_mode) begin
      e.pin = ts[0]; e.tag = "R7";
    end else if (bp < 4) begin
      e.pin = m_tab[ts][bp]; e.tag = "R8";
    end else begin
      e.pin = 1'b0; e.tag = "R9";
    end
    e.dat = d;
    sb_q.push_back(e);
    if (lk && bp == 0 && (fr % 6) == 0) m_tab[ts][4 - fr / 6] = d;
  endtask

  task automatic superframe(int seed, logic lk);
    for (int fr = 1; fr <= 24; fr++)
      for (int ts = 0; ts < 24; ts++)
        for (int bp = 7; bp >= 0; bp--)
          drive_bit(ts, bp, fr, lk, pat(fr, ts, bp, seed));
  endtask

  task automatic host_write(int a, logic [3:0] d);
    @(negedge clk);
    rx_locked = 1'b0;
    hst_wr = 1'b1; hst_addr = 6'(a); hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
    if (a < 24) m_tab[a] = d;
    else if (a == 32) m_mode = d[0];
  endtask

  task automatic host_read(int a, string tag);
    @(negedge clk);
    rx_locked = 1'b0;
    hst_rd = 1'b1; hst_addr = 6'(a);
    @(negedge clk);
    hst_rd = 1'b0;
    check(tag, {28'd0, hst_rdata}, {28'd0, mread(a)});
  endtask

  task automatic read_all(string tag);
    for (int a = 0; a < 24; a++) host_read(a, tag);
  endtask

  // Capture and host write in the same cycle.
  task automatic collide(int ts, logic d, int haddr, logic [3:0] hdata);
    exp_t e;
    @(negedge clk);
    rx_ts = 5'(ts); rx_bitpos = 3'd0; rx_frame = 5'd6; rx_locked = 1'b1; rx_bit = d;
    hst_wr = 1'b1; hst_addr = 6'(haddr); hst_wdata = hdata;
    e.pin = m_mode ? m_tab[ts][0] : ts[0];
    e.tag = m_mode ? "R8" : "R7";
    e.dat = d;
    sb_q.push_back(e);
    if (haddr != ts) m_tab[haddr] = hdata;
    m_tab[ts][3] = d;
    @(negedge clk);
    hst_wr = 1'b0; rx_locked = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    for (int i = 0; i < 24; i++) m_tab[i] = 4'h0;
    m_mode = 1'b0;
    rst_n = 1'b0; rx_bit = 1'b0; rx_ts = '0; rx_bitpos = '0; rx_frame = 5'd1;
    rx_locked = 1'b0; hst_wr = 1'b0; hst_rd = 1'b0; hst_addr = '0; hst_wdata = '0;
    repeat (4) @(negedge clk);
    check("R1 rdata in reset", {28'd0, hst_rdata}, 32'd0);
    check("R1 pcm_out in reset", {31'd0, pcm_out}, 32'd0);
    check("R1 aux_pin in reset", {31'd0, aux_pin}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    host_read(0, "R1 entry 0");
    host_read(23, "R1 entry 23");
    host_read(32, "R1 mode bit");

    // Timeslot mode, locked: capture A..D, pin follows timeslot bit 0.
    superframe(0, 1'b1);
    read_all("R2 R3 capture after pass 0");

    // Signaling mode replays what was captured, while capturing new values.
    host_write(32, 4'h1);
    host_read(32, "R5 mode bit write");
    superframe(1, 1'b1);
    read_all("R2 R3 capture after pass 1");

    // Unlocked pass: nothing captured.
    superframe(2, 1'b0);
    read_all("R4 unlocked no capture");

    // Host port behaviour.
    host_write(5, 4'hA);
    host_read(5, "R5 entry write");
    host_write(24, 4'hF);
    host_read(24, "R5 unmapped addr 24");
    host_write(40, 4'hF);
    host_read(40, "R5 unmapped addr 40");
    host_read(5, "R5 entry after unmapped writes");

    // Collisions.
    host_write(7, 4'h0);
    collide(7, 1'b1, 7, 4'h6);
    host_read(7, "R6 capture wins same entry");
    collide(9, 1'b0, 10, 4'hC);
    host_read(9, "R6 capture entry");
    host_read(10, "R6 other entry written");

    // Back to timeslot mode.
    host_write(32, 4'h0);
    for (int ts = 0; ts < 24; ts++) drive_bit(ts, 3, 2, 1'b1, pat(2, ts, 3, 5));
    host_read(32, "R5 mode bit cleared");

    repeat (3) @(posedge clk);
    #3;
    summary();
    $finish;
  end
endmodule